// File: doc/BRIEF.md
# Multi-Format ADC Result Table

This block is the result store that sits between an analog conversion sequencer and a software-visible register bus. It holds 64 conversion results of 10 bits each in a single storage array. The sequencer deposits results through a dedicated conversion write port. Software reads them back over a simple synchronous slave port, with address, write data, write strobe, read strobe and read data.

The bus address space of the table is divided into three 128-byte windows, and all of them alias the same 64 entries. The window used for a read selects how the stored 10-bit value is placed in the 16-bit bus word:
- right-aligned unsigned;
- left-aligned with the top bit inverted, which gives a half-scale-offset two's-complement value;
- left-aligned unsigned.

Software therefore picks a data format by picking an address, and no conversion code is needed. Bus writes are meant for test and debug. They always take the low 10 bits of the write data, whatever window is addressed.

Top module: `rtab_fmt_table`

## Requirements
- R1: After reset is released, `bus_rdata` reads 0x0000 until the first read completes. The stored results have no defined reset value.
- R2: Read data is registered. The formatted word appears on `bus_rdata` in the cycle after `bus_re` is sampled high. It holds unchanged in any cycle in which `bus_re` is low.
- R3: The window is decoded from `bus_addr[8:7]`. Window 0 (00) returns the entry in bits 9..0, and bits 15..10 read as zero.
- R4: Window 1 (01) returns the entry in bits 15..6 with bit 15 holding the inverted entry MSB. Bits 5..0 read as zero. Entry 0x200 therefore reads 0x0000, and entry 0x000 reads 0x8000.
- R5: Window 2 (10) returns the entry in bits 15..6 without inversion, and bits 5..0 read as zero.
- R6: Window 3 (11) is unmapped. A read there returns 0x0000, and a write there changes no entry.
- R7: The entry index is `bus_addr[6:1]` and `bus_addr[0]` is ignored. The same index in each mapped window reaches the same entry.
- R8: A bus write to any mapped window stores `bus_wdata[9:0]` in the indexed entry. Bits 15..10 of the write data are discarded.
- R9: A conversion write stores `cv_result` at `cv_idx`. When it targets the same entry as a bus write in the same cycle, the conversion value is kept. When the targets differ, both writes take effect.
- R10: A read in the same cycle as a write to the same entry returns the entry's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| bus_addr | input | 9 | Byte address within the table's bus space |
| bus_wdata | input | 16 | Bus write data; bits 9..0 are used |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 16 | Registered, formatted read data |
| cv_we | input | 1 | Conversion-side write strobe |
| cv_idx | input | 6 | Conversion-side entry index |
| cv_result | input | 10 | Conversion result to store |

## Verification
The bench targets the three values where the formats differ most: zero scale, full scale, and the midpoint 0x200, where the signed view crosses from negative to zero. A mapping that does not invert the MSB, or that inverts the wrong bit, shows up as a mismatch only in window 1. Writes carry junk in bits 15..10, and writes are also sent to the unmapped window; a design that stores upper bits or accepts unmapped writes would return corrupted entries. Same-entry collisions between the conversion port and the bus catch reversed priority. Read-during-write, and reads with `bus_addr[0]` set, catch bypassing and index decoding that uses the wrong address bits.

// File: rtl/rtab_pkg.sv
package rtab_pkg;
    localparam int RES_W  = 10;
    localparam int BUS_W  = 16;
    localparam int IDX_W  = 6;
    localparam int ADDR_W = IDX_W + 3;
    localparam int PAD_W  = BUS_W - RES_W;

    typedef enum logic [1:0] {
        WIN_RIGHT_U = 2'b00,
        WIN_LEFT_S  = 2'b01,
        WIN_LEFT_U  = 2'b10,
        WIN_NONE    = 2'b11
    } win_e;
endpackage

// File: rtl/rtab_decode.sv
module rtab_decode
    import rtab_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic [IW+2:0] addr,
    output win_e          win,
    output logic [IW-1:0] idx,
    output logic          mapped
);
    always_comb begin
        win    = win_e'(addr[IW+2:IW+1]);
        idx    = addr[IW:1];
        mapped = (win != WIN_NONE);
    end
endmodule

// File: rtl/rtab_store.sv
module rtab_store #(
    parameter int RW = 10,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          bus_wr,
    input  logic [IW-1:0] bus_idx,
    input  logic [RW-1:0] bus_val,
    input  logic          cv_wr,
    input  logic [IW-1:0] cv_idx,
    input  logic [RW-1:0] cv_val,
    input  logic [IW-1:0] rd_idx,
    output logic [RW-1:0] rd_val
);
    localparam int DEPTH = 1 << IW;

    logic [RW-1:0] mem [DEPTH];
    logic          clash;

    assign clash = cv_wr && (cv_idx == bus_idx);

    always_ff @(posedge clk) begin
        if (bus_wr && !clash) begin
            mem[bus_idx] <= bus_val;
        end
        if (cv_wr) begin
            mem[cv_idx] <= cv_val;
        end
    end

    assign rd_val = mem[rd_idx];
endmodule

// File: rtl/rtab_format.sv
module rtab_format
    import rtab_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int BW = BUS_W
) (
    input  win_e          win,
    input  logic [RW-1:0] raw,
    output logic [BW-1:0] word
);
    localparam int PW = BW - RW;

    always_comb begin
        unique case (win)
            WIN_RIGHT_U: word = {{PW{1'b0}}, raw};
            WIN_LEFT_S:  word = {~raw[RW-1], raw[RW-2:0], {PW{1'b0}}};
            WIN_LEFT_U:  word = {raw, {PW{1'b0}}};
            default:     word = '0;
        endcase
    end
endmodule

// File: rtl/rtab_fmt_table.sv
module rtab_fmt_table
    import rtab_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cv_we,
    input  logic [IDX_W-1:0]  cv_idx,
    input  logic [RES_W-1:0]  cv_result
);
    win_e             dec_win;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_mapped;
    logic [RES_W-1:0] entry_val;
    logic [BUS_W-1:0] fmt_word;

    rtab_decode #(.IW(IDX_W)) u_decode (
        .addr   (bus_addr),
        .win    (dec_win),
        .idx    (dec_idx),
        .mapped (dec_mapped)
    );

    rtab_store #(.RW(RES_W), .IW(IDX_W)) u_store (
        .clk     (clk),
        .bus_wr  (bus_we && dec_mapped),
        .bus_idx (dec_idx),
        .bus_val (bus_wdata[RES_W-1:0]),
        .cv_wr   (cv_we),
        .cv_idx  (cv_idx),
        .cv_val  (cv_result),
        .rd_idx  (dec_idx),
        .rd_val  (entry_val)
    );

    rtab_format #(.RW(RES_W), .BW(BUS_W)) u_format (
        .win  (dec_win),
        .raw  (entry_val),
        .word (fmt_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= fmt_word;
        end
    end
endmodule

// File: rtl/rtab_fmt_table_chk.sv
module rtab_fmt_table_chk
    import rtab_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_re,
    input logic [BUS_W-1:0]  bus_rdata
);
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b11) |=> (bus_rdata == '0));

    assert_right_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b00) |=> (bus_rdata[BUS_W-1:RES_W] == '0));

    assert_left_s_lower_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b01) |=> (bus_rdata[PAD_W-1:0] == '0));

    assert_left_u_lower_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b10) |=> (bus_rdata[PAD_W-1:0] == '0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_re && $past(rst_n)) |=> $stable(bus_rdata));

    assert_reset_clear_R1: assert property (@(posedge clk)
        (!rst_n) |=> (bus_rdata == '0));
endmodule

bind rtab_fmt_table rtab_fmt_table_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
);

// File: tb/rtab_fmt_table_tb.sv
`timescale 1ns/1ps
module rtab_fmt_table_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        cv_we = 1'b0;
    logic [5:0]  cv_idx = '0;
    logic [9:0]  cv_result = '0;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [9:0]  model [64];

    always #2.5 clk = ~clk;

    rtab_fmt_table u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .cv_we     (cv_we),
        .cv_idx    (cv_idx),
        .cv_result (cv_result)
    );

    function automatic logic [15:0] exp_fmt(input logic [1:0] w, input logic [9:0] v);
        case (w)
            2'b00:   return {6'b0, v};
            2'b01:   return {~v[9], v[8:0], 6'b0};
            2'b10:   return {v, 6'b0};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [8:0] mk_addr(input logic [1:0] w, input logic [5:0] i, input logic b0);
        return {w, i, b0};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a[8:7] != 2'b11) model[a[6:1]] = d[9:0];
    endtask

    task automatic conv_write(input logic [5:0] i, input logic [9:0] v);
        cv_idx = i; cv_result = v; cv_we = 1'b1;
        @(negedge clk);
        cv_we = 1'b0;
        model[i] = v;
    endtask

    task automatic bus_read(input string req, input logic [8:0] a);
        logic [15:0] e;
        e = exp_fmt(a[8:7], model[a[6:1]]);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        check(req, bus_rdata, e);
    endtask

    task automatic read_all_windows(input string req, input logic [5:0] i);
        for (int w = 0; w < 3; w++) bus_read(req, mk_addr(w[1:0], i, 1'b0));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'h5eed_0a1c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset read data", bus_rdata, 16'h0000);

        // R9: fill all entries through the conversion port
        for (int i = 0; i < 64; i++) conv_write(i[5:0], 10'($urandom));
        for (int i = 0; i < 64; i++) read_all_windows("R3/R4/R5 R9 fill", i[5:0]);

        // R8 corner values, junk upper bits, via each window
        bus_write(mk_addr(2'b00, 6'd1, 1'b0), 16'hFC00);
        read_all_windows("R4 zero scale R8", 6'd1);
        bus_write(mk_addr(2'b01, 6'd2, 1'b0), 16'hABFF);
        read_all_windows("R5 full scale R8", 6'd2);
        bus_write(mk_addr(2'b10, 6'd3, 1'b0), 16'h5600 | 16'h0200);
        read_all_windows("R4 midpoint R8", 6'd3);
        bus_write(mk_addr(2'b00, 6'd4, 1'b1), 16'h01FF);
        read_all_windows("R4 below mid R8", 6'd4);
        bus_read("R4 midpoint is zero", mk_addr(2'b01, 6'd3, 1'b0));
        check("R4 midpoint word", bus_rdata, 16'h0000);
        bus_read("R4 zero scale word", mk_addr(2'b01, 6'd1, 1'b0));
        check("R4 zero scale value", bus_rdata, 16'h8000);

        // R7 addr[0] ignored, alias
        bus_read("R7 odd byte addr", mk_addr(2'b10, 6'd2, 1'b1));
        check("R7 alias full scale", bus_rdata, 16'hFFC0);

        // R6 unmapped window
        bus_write(mk_addr(2'b11, 6'd5, 1'b0), 16'h0155);
        bus_read("R6 unmapped read", mk_addr(2'b11, 6'd5, 1'b0));
        read_all_windows("R6 unmapped write ignored", 6'd5);

        // R2 hold while idle
        bus_read("R2 read", mk_addr(2'b00, 6'd2, 1'b0));
        held = bus_rdata;
        bus_addr = mk_addr(2'b01, 6'd9, 1'b0);
        repeat (3) @(negedge clk);
        check("R2 hold", bus_rdata, held);

        // R9 collision, same entry: conversion wins
        bus_addr = mk_addr(2'b00, 6'd7, 1'b0); bus_wdata = 16'h0111; bus_we = 1'b1;
        cv_idx = 6'd7; cv_result = 10'h2AA; cv_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; cv_we = 1'b0; model[7] = 10'h2AA;
        read_all_windows("R9 same-entry priority", 6'd7);

        // R9 different entries: both stored
        bus_addr = mk_addr(2'b10, 6'd8, 1'b0); bus_wdata = 16'h0123; bus_we = 1'b1;
        cv_idx = 6'd9; cv_result = 10'h321; cv_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; cv_we = 1'b0; model[8] = 10'h123; model[9] = 10'h321;
        read_all_windows("R9 dual write bus", 6'd8);
        read_all_windows("R9 dual write conv", 6'd9);

        // R10 read during write returns old value
        bus_addr = mk_addr(2'b00, 6'd10, 1'b0);
        bus_re = 1'b1; cv_idx = 6'd10; cv_result = ~model[10]; cv_we = 1'b1;
        @(negedge clk);
        bus_re = 1'b0; cv_we = 1'b0;
        check("R10 read old value", bus_rdata, {6'b0, model[10]});
        model[10] = cv_result;
        bus_read("R10 new value after", mk_addr(2'b00, 6'd10, 1'b0));

        // random mix
        for (int k = 0; k < 600; k++) begin
            int op;
            op = int'($urandom % 3);
            if (op == 0) conv_write(6'($urandom), 10'($urandom));
            else if (op == 1) bus_write(9'($urandom), 16'($urandom));
            else bus_read("R3/R4/R5/R6 random", 9'($urandom));
        end

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule